// File: doc/BRIEF.md
# Prescaled Multi-Channel One-Shot Timer Unit

This block is the time base of a power-sequencing controller. A source selector picks which 8 MHz pulse stream feeds the prescaler: the internal oscillator, an external clock, or the shared master-clock pin. The selector also sets that pin's direction from a three-way operating mode. The 8 MHz stream enters as single-cycle enables in the fast core clock domain, one per 8 MHz period, so the block needs only one real clock.

A divide-by-32 prescaler turns the selected stream into a 250 kHz tick, a single-cycle enable. The tick drives four one-shot timers and can be sent out as the logic-clock output when its enable is set. Each timer takes a 7-bit interval code, which it reads as exponent and mantissa, so the 128 codes cover 32 µs to about 1.97 s on a non-linear scale. Start and clear controls set each timer going or stop it, and each timer reports a sticky done flag.

Top module: `seq_timer_unit`

## Requirements
- R1: The prescaler source is `mclk_pulse_i` when `mode_i` is 2'b10 (slave). In any other mode it is `ext_pulse_i` when `ext_sel_i` is 1 and `osc_pulse_i` when `ext_sel_i` is 0.
- R2: The prescaler counter moves only on a source pulse. The internal tick fires together with every 32nd source pulse after reset, and it is never high for two cycles in a row.
- R3: `lclk_o` equals the tick when `lclk_en_i` is 1 and is held at 0 when `lclk_en_i` is 0.
- R4: `mclk_oe_o` is 1 only in master mode (`mode_i` = 2'b01), and `mclk_o` then carries `osc_pulse_i`. In standalone mode (2'b00), slave mode (2'b10) and the reserved mode (2'b11, which acts as standalone), `mclk_oe_o` and `mclk_o` are 0.
- R5: Timer k reads code bits [7k+6:7k+3] as exponent e and bits [7k+2:7k] as mantissa m, giving an interval of (8+m)<<e ticks. Its done flag rises on the clock edge that takes the interval's last tick.
- R6: Once set, a done flag stays 1 until a start or a clear for that timer.
- R7: A start loads the current code and drops done on the next edge, and this holds even while the timer is running.
- R8: A clear takes priority over a start. It stops the timer and makes done 0 on the next edge, and no later tick sets done again until the timer is started again.
- R9: The four timers run independently. Start, clear and code for one timer have no effect on the others.
- R10: While `rst_ni` is low, all done flags and `lclk_o` are 0, and the prescaler and timer counts reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 standalone, 01 master, 10 slave, 11 reserved (acts as standalone) |
| ext_sel_i | input | 1 | Select the external source instead of the internal oscillator |
| osc_pulse_i | input | 1 | Internal 8 MHz oscillator as a pulse enable |
| ext_pulse_i | input | 1 | External 8 MHz clock as a pulse enable |
| mclk_pulse_i | input | 1 | Master-clock pin input as a pulse enable |
| mclk_o | output | 1 | Master-clock pin drive value |
| mclk_oe_o | output | 1 | Master-clock pin output enable |
| lclk_en_i | input | 1 | Route the 250 kHz tick to lclk_o |
| lclk_o | output | 1 | Gated 250 kHz logic-clock enable |
| code_i | input | 28 | Four 7-bit interval codes, timer 0 in the low bits |
| start_i | input | 4 | Per-timer start pulse |
| clear_i | input | 4 | Per-timer clear |
| done_o | output | 4 | Per-timer sticky timeout flag |

## Verification
The assertions take it for granted that the source pulses are already synchronous to `clk_i` and that start and clear are single-cycle strobes sampled on the same edges as the tick. They do not require any spacing between pulses. The stimulus drives every input at the falling edge from one task, so every input is a clean synchronous level. It runs the osc, ext and pin sources at different pulse rates, and only short interval codes, so that several timeouts finish in each phase. Start and clear are driven on chosen cycles to create a restart while a timer runs, a clear while it runs, and a start and clear together.

// File: rtl/seq_timer_pkg.sv
package seq_timer_pkg;
  typedef enum logic [1:0] {
    MODE_STANDALONE = 2'b00,
    MODE_MASTER     = 2'b01,
    MODE_SLAVE      = 2'b10,
    MODE_RSVD       = 2'b11
  } clk_mode_e;

  localparam int TMR_EXP_W     = 4;
  localparam int TMR_MANT_W    = 3;
  localparam int TMR_CODE_W    = TMR_EXP_W + TMR_MANT_W;
  localparam int TMR_MAX_TICKS = ((1 << (TMR_MANT_W + 1)) - 1) << ((1 << TMR_EXP_W) - 1);
  localparam int TMR_CNT_W     = $clog2(TMR_MAX_TICKS + 1);

  // (2^MANT_W + m) << e
  function automatic logic [TMR_CNT_W-1:0] decode_interval(input logic [TMR_CODE_W-1:0] code);
    logic [TMR_CNT_W-1:0] base;
    base = TMR_CNT_W'({1'b1, code[TMR_MANT_W-1:0]});
    return base << code[TMR_CODE_W-1:TMR_MANT_W];
  endfunction
endpackage

// File: rtl/clk_src_sel.sv
module clk_src_sel
  import seq_timer_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       ext_sel_i,
  input  logic       osc_pulse_i,
  input  logic       ext_pulse_i,
  input  logic       mclk_pulse_i,
  output logic       src_pulse_o,
  output logic       mclk_o,
  output logic       mclk_oe_o
);
  clk_mode_e mode;
  assign mode = clk_mode_e'(mode_i);

  always_comb begin
    src_pulse_o = ext_sel_i ? ext_pulse_i : osc_pulse_i;
    mclk_o      = 1'b0;
    mclk_oe_o   = 1'b0;
    unique case (mode)
      MODE_MASTER: begin
        mclk_oe_o = 1'b1;
        mclk_o    = osc_pulse_i;
      end
      MODE_SLAVE: src_pulse_o = mclk_pulse_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_pulse_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = src_pulse_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else if (src_pulse_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import seq_timer_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [TMR_CODE_W-1:0] code_i,
  input  logic                  start_i,
  input  logic                  clear_i,
  output logic                  done_o
);
  logic [TMR_CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= decode_interval(code_i);
      done_o <= 1'b0;
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == TMR_CNT_W'(1)) done_o <= 1'b1;
    end
  end
endmodule

// File: rtl/seq_timer_unit.sv
module seq_timer_unit
  import seq_timer_pkg::*;
#(
  parameter int N_TIMERS = 4,
  parameter int DIV      = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [1:0]                     mode_i,
  input  logic                           ext_sel_i,
  input  logic                           osc_pulse_i,
  input  logic                           ext_pulse_i,
  input  logic                           mclk_pulse_i,
  output logic                           mclk_o,
  output logic                           mclk_oe_o,
  input  logic                           lclk_en_i,
  output logic                           lclk_o,
  input  logic [N_TIMERS*TMR_CODE_W-1:0] code_i,
  input  logic [N_TIMERS-1:0]            start_i,
  input  logic [N_TIMERS-1:0]            clear_i,
  output logic [N_TIMERS-1:0]            done_o
);
  logic src_pulse;
  logic tick;

  clk_src_sel i_sel (
    .mode_i       (mode_i),
    .ext_sel_i    (ext_sel_i),
    .osc_pulse_i  (osc_pulse_i),
    .ext_pulse_i  (ext_pulse_i),
    .mclk_pulse_i (mclk_pulse_i),
    .src_pulse_o  (src_pulse),
    .mclk_o       (mclk_o),
    .mclk_oe_o    (mclk_oe_o)
  );

  tick_prescaler #(.DIV(DIV)) i_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_pulse_i (src_pulse),
    .tick_o      (tick)
  );

  assign lclk_o = lclk_en_i & tick;

  for (genvar k = 0; k < N_TIMERS; k++) begin : g_tmr
    oneshot_timer i_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .code_i  (code_i[k*TMR_CODE_W +: TMR_CODE_W]),
      .start_i (start_i[k]),
      .clear_i (clear_i[k]),
      .done_o  (done_o[k])
    );
  end
endmodule

// File: rtl/seq_timer_unit_chk.sv
module seq_timer_unit_chk #(
  parameter int N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   mode_i,
  input logic         mclk_oe_o,
  input logic         lclk_en_i,
  input logic         lclk_o,
  input logic         tick,
  input logic [N-1:0] start_i,
  input logic [N-1:0] clear_i,
  input logic [N-1:0] done_o
);
  // R2
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);

  // R3
  lclk_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lclk_o |-> (lclk_en_i && tick));

  // R4
  mclk_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclk_oe_o |-> (mode_i == 2'b01));

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R5
    done_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o[k]) |-> $past(tick));

    // R6
    done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o[k] && !start_i[k] && !clear_i[k]) |=> done_o[k]);

    // R7
    start_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i[k] |=> !done_o[k]);

    // R8
    clear_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i[k] |=> !done_o[k]);
  end
endmodule

bind seq_timer_unit seq_timer_unit_chk #(.N(N_TIMERS)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .mclk_oe_o (mclk_oe_o),
  .lclk_en_i (lclk_en_i),
  .lclk_o    (lclk_o),
  .tick      (tick),
  .start_i   (start_i),
  .clear_i   (clear_i),
  .done_o    (done_o)
);

// File: tb/test_seq_timer_unit.sv
module test_seq_timer_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        ext_sel_i = 1'b0;
  logic        osc_pulse_i = 1'b0;
  logic        ext_pulse_i = 1'b0;
  logic        mclk_pulse_i = 1'b0;
  logic        mclk_o, mclk_oe_o, lclk_o;
  logic        lclk_en_i = 1'b0;
  logic [27:0] code_i = '0;
  logic [3:0]  start_i = '0;
  logic [3:0]  clear_i = '0;
  logic [3:0]  done_o;

  int n_cmp = 0, n_bad = 0;
  int osc_per = 1, ext_per = 3, pin_per = 2;
  int cyc = 0;
  int m_pc = 0;
  int m_cnt[4] = '{0, 0, 0, 0};
  bit m_done[4] = '{0, 0, 0, 0};
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  seq_timer_unit i_seq_timer_unit (.*);

  task automatic check(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got %b expected %b", req, cyc, act, exp);
    end
  endtask

  function automatic bit src_now();
    if (mode_i == 2'b10) return mclk_pulse_i;
    return ext_sel_i ? ext_pulse_i : osc_pulse_i;
  endfunction

  // one clock: drive pulses, check comb outputs, step model, check done
  task automatic step();
    bit s, t;
    osc_pulse_i  = (cyc % osc_per) == 0;
    ext_pulse_i  = (cyc % ext_per) == 0;
    mclk_pulse_i = (cyc % pin_per) == 0;
    #1;
    s = src_now();
    t = s && (m_pc == 31);
    check("R1/R2/R3 lclk", lclk_o, lclk_en_i && t);
    check("R4 mclk_oe", mclk_oe_o, mode_i == 2'b01);
    check("R4 mclk", mclk_o, (mode_i == 2'b01) && osc_pulse_i);
    @(posedge clk_i);
    if (s) m_pc = (m_pc + 1) % 32;
    for (int k = 0; k < 4; k++) begin
      int e, m;
      e = code_i[k*7+3 +: 4];
      m = code_i[k*7 +: 3];
      if (clear_i[k]) begin
        m_cnt[k] = 0; m_done[k] = 0;
      end else if (start_i[k]) begin
        m_cnt[k] = (8 + m) << e; m_done[k] = 0;
      end else if (t && m_cnt[k] != 0) begin
        m_cnt[k]--;
        if (m_cnt[k] == 0) m_done[k] = 1;
      end
    end
    @(negedge clk_i);
    cyc++;
    for (int k = 0; k < 4; k++) check("R5-done", done_o[k], m_done[k]);
    start_i = '0;
    clear_i = '0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk_i);
    check("R10 done", |done_o, 1'b0);
    check("R10 lclk", lclk_o, 1'b0);
    rst_ni = 1'b1;

    // R5 R9: four codes at once, osc source every cycle
    code_i = {7'h0B, 7'h08, 7'h01, 7'h00}; // 22,16,9,8 ticks
    lclk_en_i = 1'b1;
    start_i = 4'hF;
    run(800);
    // R6: all done and held
    check("R6 held", &done_o, 1'b1);

    // R3: gate off
    lclk_en_i = 1'b0;
    run(70);

    // R7: restart timer0 while running
    code_i[6:0] = 7'h08;
    start_i = 4'b0001;
    run(200);
    start_i = 4'b0001;
    run(400);

    // R8: clear timer1 while running, start+clear together on timer2
    code_i[13:7] = 7'h00;
    start_i = 4'b0010;
    run(100);
    clear_i = 4'b0110;
    start_i = 4'b0100;
    run(500);
    check("R8 cleared stays low", done_o[1], 1'b0);

    // R9: long timer2 while timer3 restarted
    code_i[20:14] = 7'h18; // 64 ticks
    start_i = 4'b1100;
    run(2200);

    // R1: external source, slower pulses
    ext_sel_i = 1'b1;
    lclk_en_i = 1'b1;
    start_i = 4'b1111;
    run(3000);

    // R1 R4: slave mode, pin source
    mode_i = 2'b10;
    start_i = 4'b1111;
    run(2000);

    // R4: master mode and reserved mode
    mode_i = 2'b01;
    ext_sel_i = 1'b0;
    osc_per = 2;
    start_i = 4'b1111;
    run(1600);
    mode_i = 2'b11;
    start_i = 4'b0011;
    run(600);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule